// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Unit

This block performs one multiply or multiply-accumulate operation for each accepted request. Two 64-bit register operands are multiplied, and the product is added to or subtracted from a left-hand value. That value is either zero or the contents of the accumulator, which the block holds in its own HI and LO registers. Per-request mode bits choose signed or unsigned arithmetic, optional saturation, 16-bit short operands, and the accumulator layout: split across HI and LO, or whole in LO.

Before the operation is committed, each operand is checked for canonical form. An operand that fails the check raises an error flag and leaves all state untouched. On success the accumulator is updated. When the request names a nonzero destination index, the block also presents a register write that carries the new HI or the new LO. A pipeline drives requests with a valid/ready handshake and sees the response exactly one cycle after the request is accepted.

Top module: `mac_unit`

## Requirements
- R1: `req_ready` is high whenever the block is out of reset, and a request is accepted in a cycle where `req_valid` and `req_ready` are both high. `rsp_valid` is high in the cycle after an acceptance and low in every other cycle. HI, LO and the register write change only at acceptance edges.
- R2: While `rst_n` is low, and until two clock edges after it rises, HI and LO are zero and `rsp_valid`, `wr_en` and `req_ready` are low.
- R3: The left-hand value is chosen as follows. It is zero when `req_acc` is 0. It is all 64 bits of LO when `req_acc` and `req_dbl` are both 1. In the remaining case it is HI bits 31:0 placed above LO bits 31:0.
- R4: Operand validity depends on the effective short mode. With short mode off, an operand is valid only if it equals the sign extension of its bits 31:0. With short mode on and `req_uns` = 1, bits 63:16 must be zero. With short mode on and `req_uns` = 0, the operand must equal the sign extension of its bits 15:0. If either operand is invalid, `rsp_err` = 1.
- R5: With `req_uns` = 1, the product is bits 31:0 of one operand times bits 31:0 of the other, both zero-extended. With `req_uns` = 0, both are sign-extended. The product keeps 64 bits.
- R6: With `req_sub` = 1, the result is the left-hand value minus the product. Otherwise it is the left-hand value plus the product. Both use 64-bit wraparound.
- R7: Signed saturation applies when `req_sat` = 1 and `req_uns` = 0. A result outside the signed 32-bit range becomes 0x000000007FFFFFFF if it is non-negative and 0xFFFFFFFF80000000 if it is negative. Results inside the range pass through unchanged.
- R8: Unsigned saturation applies when `req_sat` = 1 and `req_uns` = 1. Any set bit in result bits 63:32 turns all 64 bits to one. Other results pass through unchanged.
- R9: With `req_dbl` = 1, LO takes the 64-bit result and HI is unchanged. With `req_dbl` = 0, LO takes the sign extension of result bits 31:0 and HI takes the sign extension of result bits 63:32.
- R10: A successful request with a nonzero `req_dst` gives `wr_en` = 1 and `wr_idx` = `req_dst`. The write carries the new HI when `req_hisel` = 1 and the new LO otherwise. When `req_dst` = 0, `wr_en` stays 0.
- R11: A request that raises `rsp_err` leaves HI and LO unchanged and gives `wr_en` = 0.
- R12: When `req_sat_short` = 1, setting `req_sat` also turns on short operand mode, even if `req_short` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_a | input | 64 | First multiplier operand |
| req_b | input | 64 | Second multiplier operand |
| req_dst | input | 5 | Destination register index; 0 means no write |
| req_acc | input | 1 | Use the accumulator as the left-hand value |
| req_sub | input | 1 | Subtract the product instead of adding it |
| req_uns | input | 1 | Unsigned operands and product |
| req_sat | input | 1 | Saturate the result |
| req_short | input | 1 | 16-bit short operand mode |
| req_dbl | input | 1 | Whole accumulator held in LO |
| req_hisel | input | 1 | Register write carries HI instead of LO |
| req_sat_short | input | 1 | Saturate also forces short mode |
| rsp_valid | output | 1 | Response for the request accepted in the previous cycle |
| rsp_err | output | 1 | That request had an invalid operand |
| wr_en | output | 1 | Register write valid |
| wr_idx | output | 5 | Register write index |
| wr_data | output | 64 | Register write data |
| acc_hi | output | 64 | Current HI register |
| acc_lo | output | 64 | Current LO register |

## Verification
Several properties are checked on every cycle. The response must follow acceptance by exactly one cycle. HI and LO must hold when nothing is accepted, when an operand error occurs, and (for HI) in double mode. A successful split-mode update must leave HI as a sign-extended 32-bit value, and a register write must never target index zero. The bench's scenarios are needed for the rest, because each depends on specific values: the exact products, the accumulation chains across back-to-back requests, the two saturation clamps and the all-ones unsigned overflow, the operand-validity decisions in each short mode, and the saturate-forces-short link.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef struct packed {
    logic acc;
    logic sub;
    logic uns;
    logic sat;
    logic sht;
    logic dbl;
    logic hsel;
    logic sat_sht;
  } mac_mode_t;
endpackage

// File: rtl/mac_opnd_chk.sv
module mac_opnd_chk #(
  parameter int XLEN    = 64,
  parameter int SHORT_W = 16
) (
  input  logic [XLEN-1:0] opnd,
  input  logic            short_mode,
  input  logic            uns,
  output logic            ok
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] canon_long;
  logic [XLEN-1:0] canon_short_s;
  logic [XLEN-1:0] canon_short_u;

  always_comb begin
    canon_long    = {{HALF{opnd[HALF-1]}}, opnd[HALF-1:0]};
    canon_short_s = {{(XLEN-SHORT_W){opnd[SHORT_W-1]}}, opnd[SHORT_W-1:0]};
    canon_short_u = {{(XLEN-SHORT_W){1'b0}}, opnd[SHORT_W-1:0]};
    if (!short_mode)
      ok = (opnd == canon_long);
    else if (uns)
      ok = (opnd == canon_short_u);
    else
      ok = (opnd == canon_short_s);
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] lhs,
  input  mac_mode_t       mode,
  output logic [XLEN-1:0] result
);
  localparam int HALF = XLEN / 2;
  localparam logic [XLEN-1:0] POS_CLAMP = {{(HALF+1){1'b0}}, {(HALF-1){1'b1}}};
  localparam logic [XLEN-1:0] NEG_CLAMP = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};

  logic [XLEN-1:0] ext_a, ext_b, prod, sum;
  logic            s_ovf, u_ovf;

  always_comb begin
    if (mode.uns) begin
      ext_a = {{HALF{1'b0}}, a[HALF-1:0]};
      ext_b = {{HALF{1'b0}}, b[HALF-1:0]};
    end else begin
      ext_a = {{HALF{a[HALF-1]}}, a[HALF-1:0]};
      ext_b = {{HALF{b[HALF-1]}}, b[HALF-1:0]};
    end
    prod  = ext_a * ext_b;
    sum   = mode.sub ? (lhs - prod) : (lhs + prod);
    s_ovf = (sum != {{HALF{sum[HALF-1]}}, sum[HALF-1:0]});
    u_ovf = |sum[XLEN-1:HALF];
    result = sum;
    if (mode.sat) begin
      if (!mode.uns && s_ovf)
        result = sum[XLEN-1] ? NEG_CLAMP : POS_CLAMP;
      else if (mode.uns && u_ovf)
        result = '1;
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int IDX_W   = 5,
  parameter int SHORT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [XLEN-1:0]  req_a,
  input  logic [XLEN-1:0]  req_b,
  input  logic [IDX_W-1:0] req_dst,
  input  logic             req_acc,
  input  logic             req_sub,
  input  logic             req_uns,
  input  logic             req_sat,
  input  logic             req_short,
  input  logic             req_dbl,
  input  logic             req_hisel,
  input  logic             req_sat_short,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [XLEN-1:0]  wr_data,
  output logic [XLEN-1:0]  acc_hi,
  output logic [XLEN-1:0]  acc_lo
);
  localparam int HALF  = XLEN / 2;
  localparam int N_OPS = 2;

  // reset synchroniser: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok    = rst_pipe[1];
  assign req_ready = rst_ok;

  mac_mode_t mode;
  assign mode = '{acc: req_acc, sub: req_sub, uns: req_uns, sat: req_sat,
                  sht: req_short, dbl: req_dbl, hsel: req_hisel,
                  sat_sht: req_sat_short};

  logic                 short_eff;
  logic [XLEN-1:0]      opnd [N_OPS];
  logic [N_OPS-1:0]     opnd_ok;
  assign short_eff = mode.sht | (mode.sat & mode.sat_sht);
  assign opnd[0]   = req_a;
  assign opnd[1]   = req_b;

  for (genvar g = 0; g < N_OPS; g++) begin : g_chk
    mac_opnd_chk #(.XLEN(XLEN), .SHORT_W(SHORT_W)) u_chk (
      .opnd       (opnd[g]),
      .short_mode (short_eff),
      .uns        (mode.uns),
      .ok         (opnd_ok[g])
    );
  end

  logic [XLEN-1:0]  hi_q, lo_q, lhs, result, new_hi, new_lo;
  logic [XLEN-1:0]  hi_d, lo_d, wdata_q, wdata_d;
  logic [IDX_W-1:0] widx_q, widx_d;
  logic             accept, commit, fault;
  logic             rspv_q, rspv_d, err_q, err_d, wen_q, wen_d;

  always_comb begin
    if (!mode.acc)     lhs = '0;
    else if (mode.dbl) lhs = lo_q;
    else               lhs = {hi_q[HALF-1:0], lo_q[HALF-1:0]};
  end

  mac_datapath #(.XLEN(XLEN)) u_dp (
    .a      (req_a),
    .b      (req_b),
    .lhs    (lhs),
    .mode   (mode),
    .result (result)
  );

  // next-state logic
  always_comb begin
    accept = req_valid & rst_ok;
    fault  = accept & ~(&opnd_ok);
    commit = accept & (&opnd_ok);
    if (mode.dbl) begin
      new_lo = result;
      new_hi = hi_q;
    end else begin
      new_lo = {{HALF{result[HALF-1]}}, result[HALF-1:0]};
      new_hi = {{HALF{result[XLEN-1]}}, result[XLEN-1:HALF]};
    end
    hi_d    = hi_q;
    lo_d    = lo_q;
    widx_d  = widx_q;
    wdata_d = wdata_q;
    wen_d   = 1'b0;
    rspv_d  = accept;
    err_d   = fault;
    if (commit) begin
      hi_d = new_hi;
      lo_d = new_lo;
      if (req_dst != '0) begin
        wen_d   = 1'b1;
        widx_d  = req_dst;
        wdata_d = mode.hsel ? new_hi : new_lo;
      end
    end
  end

  // registers, clock enable on commit for the wide state
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      hi_q    <= '0;
      lo_q    <= '0;
      widx_q  <= '0;
      wdata_q <= '0;
      wen_q   <= 1'b0;
      rspv_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      rspv_q <= rspv_d;
      err_q  <= err_d;
      wen_q  <= wen_d;
      if (commit) begin
        hi_q    <= hi_d;
        lo_q    <= lo_d;
        widx_q  <= widx_d;
        wdata_q <= wdata_d;
      end
    end
  end

  assign rsp_valid = rspv_q;
  assign rsp_err   = err_q;
  assign wr_en     = wen_q;
  assign wr_idx    = widx_q;
  assign wr_data   = wdata_q;
  assign acc_hi    = hi_q;
  assign acc_lo    = lo_q;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_dbl,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [XLEN-1:0]  acc_hi,
  input logic [XLEN-1:0]  acc_lo
);
  localparam int HALF = XLEN / 2;

  assert_rsp_timing_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    rsp_valid == $past(req_valid && req_ready));

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    !$past(req_valid && req_ready) |-> ($stable(acc_hi) && $stable(acc_lo) && !wr_en));

  assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    (rsp_valid && rsp_err) |-> ($stable(acc_hi) && $stable(acc_lo) && !wr_en));

  assert_dbl_keeps_hi_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(req_valid && req_ready && req_dbl) |-> $stable(acc_hi));

  assert_split_hi_sext_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (rsp_valid && !rsp_err && !$past(req_dbl)) |->
      (acc_hi[XLEN-1:HALF] == {HALF{acc_hi[HALF-1]}}));

  assert_no_zero_write_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_en |-> (wr_idx != '0 && rsp_valid && !rsp_err));

  always_comb begin
    if (!rst_ok) assert_reset_state_R2: assert (acc_hi == '0 && acc_lo == '0 && !rsp_valid && !req_ready);
  end
endmodule

bind mac_unit mac_unit_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_mac_unit_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_dbl   (req_dbl),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .acc_hi    (acc_hi),
  .acc_lo    (acc_lo)
);

// File: tb/test_mac_unit.sv
`timescale 1ns/1ps
module test_mac_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [63:0] req_a, req_b;
  logic [4:0]  req_dst;
  logic        req_acc, req_sub, req_uns, req_sat, req_short, req_dbl, req_hisel, req_sat_short;
  logic        rsp_valid, rsp_err, wr_en;
  logic [4:0]  wr_idx;
  logic [63:0] wr_data, acc_hi, acc_lo;

  always #10 clk = ~clk;

  mac_unit i_mac_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_a(req_a), .req_b(req_b), .req_dst(req_dst), .req_acc(req_acc),
    .req_sub(req_sub), .req_uns(req_uns), .req_sat(req_sat), .req_short(req_short),
    .req_dbl(req_dbl), .req_hisel(req_hisel), .req_sat_short(req_sat_short),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  int total = 0;
  int fails = 0;
  bit done  = 0;

  // reference model state
  longint m_hi, m_lo;
  bit     e_rsp, e_err, e_wen;
  logic [4:0]  e_idx;
  longint e_wdata;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, {63'd0, req_ready}, 64'd1, "req_ready");
    chk(tag, {63'd0, rsp_valid}, {63'd0, e_rsp}, "rsp_valid");
    chk(tag, {63'd0, rsp_err}, {63'd0, e_err}, "rsp_err");
    chk(tag, {63'd0, wr_en}, {63'd0, e_wen}, "wr_en");
    if (e_wen) begin
      chk(tag, {59'd0, wr_idx}, {59'd0, e_idx}, "wr_idx");
      chk(tag, wr_data, e_wdata, "wr_data");
    end
    chk(tag, acc_hi, m_hi, "acc_hi");
    chk(tag, acc_lo, m_lo, "acc_lo");
  endtask

  function automatic bit valid_opnd(input logic [63:0] v, input bit sht, input bit uns);
    if (!sht)    return longint'($signed(v[31:0])) == longint'(v);
    else if (uns) return v < 64'd65536;
    else          return longint'($signed(v[15:0])) == longint'(v);
  endfunction

  // model of one request; called before the edge that accepts it
  task automatic model(input logic [63:0] a, input logic [63:0] b, input logic [4:0] dst,
                       input bit acc, input bit sub, input bit uns, input bit sat,
                       input bit sht, input bit dbl, input bit hsel, input bit tie);
    bit sht_eff = sht || (sat && tie);
    longint lhs, pa, pb, res;
    e_rsp = 1; e_wen = 0;
    if (!valid_opnd(a, sht_eff, uns) || !valid_opnd(b, sht_eff, uns)) begin
      e_err = 1;
      return;
    end
    e_err = 0;
    if (!acc) lhs = 0;
    else if (dbl) lhs = m_lo;
    else lhs = (m_hi << 32) | (m_lo & 64'h0000_0000_FFFF_FFFF);
    pa = uns ? longint'({32'd0, a[31:0]}) : longint'($signed(a[31:0]));
    pb = uns ? longint'({32'd0, b[31:0]}) : longint'($signed(b[31:0]));
    res = sub ? lhs - pa * pb : lhs + pa * pb;
    if (sat && !uns) begin
      if (res > 64'sd2147483647) res = 64'sd2147483647;
      else if (res < -64'sd2147483648) res = -64'sd2147483648;
    end else if (sat && uns && (res[63:32] != 0)) res = -1;
    if (dbl) m_lo = res;
    else begin
      m_lo = longint'($signed(res[31:0]));
      m_hi = longint'($signed(res[63:32]));
    end
    if (dst != 0) begin
      e_wen = 1; e_idx = dst; e_wdata = hsel ? m_hi : m_lo;
    end
  endtask

  // drive a request at a falling edge, compare at the next falling edge
  task automatic req(input string tag, input logic [63:0] a, input logic [63:0] b, input logic [4:0] dst,
                     input bit acc, input bit sub, input bit uns, input bit sat,
                     input bit sht, input bit dbl, input bit hsel, input bit tie);
    req_valid = 1; req_a = a; req_b = b; req_dst = dst; req_acc = acc; req_sub = sub;
    req_uns = uns; req_sat = sat; req_short = sht; req_dbl = dbl; req_hisel = hsel; req_sat_short = tie;
    model(a, b, dst, acc, sub, uns, sat, sht, dbl, hsel, tie);
    @(negedge clk);
    compare(tag);
  endtask

  // idle cycle: inputs change but nothing is accepted
  task automatic idle(input string tag);
    req_valid = 0; req_a = 64'hDEAD; req_b = 64'h3; req_dst = 5'd9; req_acc = 1; req_sub = 1;
    e_rsp = 0; e_err = 0; e_wen = 0;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_a = 0; req_b = 0; req_dst = 0;
    req_acc = 0; req_sub = 0; req_uns = 0; req_sat = 0; req_short = 0;
    req_dbl = 0; req_hisel = 0; req_sat_short = 0;
    m_hi = 0; m_lo = 0; e_rsp = 0; e_err = 0; e_wen = 0; e_idx = 0; e_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R2", {63'd0, req_ready}, 64'd0, "req_ready in reset");
    chk("R2", acc_hi | acc_lo, 64'd0, "acc in reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    compare("R2");

    //       tag    a                        b                        dst  acc sub uns sat sht dbl hs tie
    req("R5",  -64'sd3,                 64'd7,                   5'd3, 0,0,0,0,0,0,0,0);
    req("R5",  64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 5'd4, 0,0,1,0,0,0,1,0);
    req("R3",  64'd1000,                64'd1000,                5'd5, 1,0,1,0,0,0,1,0);
    req("R6",  64'd5,                   64'd9,                   5'd6, 1,1,0,0,0,0,0,0);
    req("R6",  64'h7FFF_FFFF,           64'h7FFF_FFFF,           5'd6, 1,1,0,0,0,0,1,0);
    idle("R1");
    req("R9",  64'd12345,               64'd54321,               5'd7, 0,0,0,0,0,1,0,0);
    req("R3",  64'd5,                   64'd6,                   5'd7, 1,0,0,0,0,1,0,0);
    req("R9",  64'd100000,              64'd100000,              5'd8, 1,1,0,0,0,1,1,0);
    req("R7",  64'h7FFF_FFFF,           64'd2,                   5'd1, 0,0,0,1,0,0,0,0);
    req("R7",  64'h7FFF_FFFF,           -64'sd2,                 5'd1, 0,0,0,1,0,0,1,0);
    req("R7",  64'd100,                 -64'sd5,                 5'd1, 0,0,0,1,0,0,0,0);
    req("R8",  64'h1_0000,              64'h1_0000,              5'd2, 0,0,1,1,0,0,0,0);
    req("R8",  64'h7FFF,                64'd3,                   5'd2, 0,0,1,1,0,0,0,0);
    req("R4",  64'h1_0000_0000,         64'd3,                   5'd2, 1,0,0,0,0,0,0,0);
    req("R11", 64'd3,                   64'h0000_0000_8000_0000, 5'd2, 1,0,0,0,0,1,0,0);
    req("R4",  -64'sd5,                 64'd300,                 5'd3, 0,0,0,0,1,0,0,0);
    req("R4",  64'h1_0000,              64'd2,                   5'd3, 0,0,0,0,1,0,0,0);
    req("R4",  64'hFFFF,                64'd2,                   5'd3, 0,0,1,0,1,0,0,0);
    req("R4",  64'hFFFF_FFFF_FFFF_FFFF, 64'd2,                   5'd3, 0,0,1,0,1,0,0,0);
    req("R12", 64'h1_2345,              64'd2,                   5'd3, 1,0,0,1,0,0,0,1);
    req("R12", 64'h100,                 64'h100,                 5'd3, 1,0,1,1,0,0,0,1);
    req("R12", 64'h1_2345,              64'd2,                   5'd3, 0,0,0,1,0,0,0,0);
    req("R10", 64'd11,                  64'd13,                  5'd0, 0,0,0,0,0,0,1,0);
    req("R10", 64'd11,                  64'd13,                  5'd31,1,0,0,0,0,0,1,0);
    idle("R1");
    idle("R1");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule